// File: doc/BRIEF.md
# I2C Slave Command Receiver

This block is the two-wire serial front end of a display controller. It watches the clock and data lines and oversamples them with its own system clock. It finds START and STOP conditions and compares the first byte of each transfer against its own 7-bit address. Five address bits are fixed by a parameter and the two lowest come from strap inputs. The block answers on a data output that is separate from the data input, so an acknowledge is a low level on its own pin. The board combines that pin with the host's drive.

In a write transfer the payload is framed as command words. A control byte carries a continuation flag and a data/command flag, and each control byte is followed by two payload bytes. The block hands every payload byte downstream as a one-cycle strobe, together with the byte value and a flag. The flag says whether the byte is display memory content or an instruction. In a read transfer the block shifts out either its own address or an externally supplied status byte, most significant bit first. It repeats that byte for as long as the host acknowledges.

Top module: `i2c_cmd_rx`

## Requirements
- R1: After reset the data output is released (1) and no byte strobe is given.
- R2: The device address is {01111, strap_i[1], strap_i[0]}. A first byte whose upper seven bits match it is acknowledged by sda_o = 0 during the ninth SCL clock, and bit 0 of that byte selects write (0) or read (1).
- R3: After an address that does not match, sda_o stays 1 and no byte strobe is given until the next START.
- R4: A falling SDA while SCL is high is a START. A rising SDA while SCL is high is a STOP, and a STOP leaves the block idle with sda_o = 1.
- R5: In a write transfer every byte after the address is acknowledged in its ninth clock.
- R6: The first byte after the address is a control byte: bit 7 is the continuation flag and bit 6 the data/command flag. A control byte produces no strobe.
- R7: Each payload byte produces exactly one strobe, with byte_o equal to the byte. byte_dc_o is 1 for display data (flag = 1) and 0 for an instruction (flag = 0).
- R8: When the continuation flag is 1, the byte after the two payload bytes is again a control byte.
- R9: When the continuation flag is 0, every byte after the two payload bytes up to the end of the transfer is payload with the last data/command flag.
- R10: In a read transfer the block drives the byte MSB first, changing sda_o only while SCL is low. The byte is {0, device address} when rd_status_i = 0 and status_i when rd_status_i = 1.
- R11: After a host acknowledge the same byte is sent again. After a host not-acknowledge sda_o stays 1 until the next START.
- R12: A repeated START restarts the address phase, and the next write byte is taken as a control byte.
- R13: byte_stb_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| strap_i | input | 2 | Low address bits from strap pins |
| rd_status_i | input | 1 | Read source: 0 address, 1 status byte |
| status_i | input | 8 | Status byte returned in read transfers |
| sda_o | output | 1 | Data output, 0 pulls the line low, 1 releases it |
| byte_stb_o | output | 1 | One-cycle strobe for a received payload byte |
| byte_dc_o | output | 1 | 1 display data, 0 instruction |
| byte_o | output | 8 | Payload byte value |

## Verification
The hardest state to reach is a repeated START that lands in the middle of a command word. The framer must then drop a partly consumed control context and treat the next byte as a new control byte. The bench gets there with a directed transfer that opens a non-continued word and is cut off after one payload byte. It then sends a second address and a control byte of all zeros, which would come out as payload if the framing state survived. Randomised write transfers cover control bytes with either continuation value placed at arbitrary points, of varying length and strap setting, and these are compared against a bench-side framing model. Read transfers end in both host acknowledge and host not-acknowledge.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

   typedef enum logic [2:0] {
      BS_IDLE,
      BS_ADDR,
      BS_ADDR_ACK,
      BS_WR,
      BS_WR_ACK,
      BS_RD,
      BS_RD_ACK,
      BS_SKIP
   } bus_st_t;

   typedef enum logic [1:0] {
      FR_CTRL,
      FR_D1,
      FR_D2,
      FR_STREAM
   } fr_st_t;

endpackage

// File: rtl/i2c_cmd_linesync.sv
module i2c_cmd_linesync #(
   parameter int SYNC_STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
         scl_q  <= scl_ff[SYNC_STAGES-1];
         sda_q  <= sda_ff[SYNC_STAGES-1];
      end
   end

   assign scl_s    = scl_ff[SYNC_STAGES-1];
   assign sda_s    = sda_ff[SYNC_STAGES-1];
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_cmd_framer.sv
module i2c_cmd_framer import i2c_cmd_pkg::*; #(
   parameter int BYTE_W = 8,
   parameter int CO_POS = 7,
   parameter int DC_POS = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   output logic              stb_o,
   output logic              dc_o,
   output logic [BYTE_W-1:0] byte_o
);

   if (CO_POS == DC_POS || CO_POS >= BYTE_W || DC_POS >= BYTE_W) begin : g_bad_pos
      $error("control flag positions must be distinct and inside the byte");
   end

   fr_st_t st;
   logic   co_q, dc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= FR_CTRL;
         co_q   <= 1'b0;
         dc_q   <= 1'b0;
         stb_o  <= 1'b0;
         dc_o   <= 1'b0;
         byte_o <= '0;
      end else begin
         stb_o <= 1'b0;
         if (clear_i) begin
            st <= FR_CTRL;
         end else if (vld_i) begin
            case (st)
               FR_CTRL: begin
                  co_q <= byte_i[CO_POS];
                  dc_q <= byte_i[DC_POS];
                  st   <= FR_D1;
               end
               FR_D1: begin
                  stb_o  <= 1'b1;
                  dc_o   <= dc_q;
                  byte_o <= byte_i;
                  st     <= FR_D2;
               end
               FR_D2: begin
                  stb_o  <= 1'b1;
                  dc_o   <= dc_q;
                  byte_o <= byte_i;
                  st     <= co_q ? FR_CTRL : FR_STREAM;
               end
               default: begin
                  stb_o  <= 1'b1;
                  dc_o   <= dc_q;
                  byte_o <= byte_i;
               end
            endcase
         end
      end
   end

   p_ctrl_hidden_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && !clear_i && st == FR_CTRL) |=> !stb_o);

   p_single_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |=> !stb_o);

   p_stream_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && !clear_i && st == FR_STREAM) |=> (stb_o && dc_o == $past(dc_q)));

endmodule

// File: rtl/i2c_cmd_rx.sv
module i2c_cmd_rx import i2c_cmd_pkg::*; #(
   parameter int                          SYNC_STAGES = 2,
   parameter int                          ADDR_W      = 7,
   parameter int                          STRAP_W     = 2,
   parameter logic [ADDR_W-STRAP_W-1:0]   ADDR_FIXED  = 5'b01111,
   parameter int                          BYTE_W      = 8,
   parameter int                          CO_POS      = 7,
   parameter int                          DC_POS      = 6
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   input  logic               rd_status_i,
   input  logic [BYTE_W-1:0]  status_i,
   output logic               sda_o,
   output logic               byte_stb_o,
   output logic               byte_dc_o,
   output logic [BYTE_W-1:0]  byte_o
);

   localparam int               CNT_W    = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   if (ADDR_W + 1 != BYTE_W) begin : g_bad_width
      $error("address plus direction bit must fill one byte");
   end
   if (STRAP_W >= ADDR_W) begin : g_bad_strap
      $error("strap bits must leave fixed address bits");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;

   i2c_cmd_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_p  (start_p),
      .stop_p   (stop_p)
   );

   bus_st_t           st;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] rx_sh, tx_sh;
   logic              got, rd_mode, m_ack, pay_vld;
   logic [ADDR_W-1:0] dev_addr;
   logic [BYTE_W-1:0] rd_byte;

   assign dev_addr = {ADDR_FIXED, strap_i};
   assign rd_byte  = rd_status_i ? status_i : {1'b0, dev_addr};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= BS_IDLE;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '1;
         got     <= 1'b0;
         rd_mode <= 1'b0;
         m_ack   <= 1'b0;
         pay_vld <= 1'b0;
      end else begin
         pay_vld <= 1'b0;
         if (start_p) begin
            st      <= BS_ADDR;
            bit_cnt <= '0;
            got     <= 1'b0;
         end else if (stop_p) begin
            st  <= BS_IDLE;
            got <= 1'b0;
         end else begin
            case (st)
               BS_ADDR, BS_WR: begin
                  if (scl_rise) begin
                     rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                     if (bit_cnt == LAST_BIT) begin
                        got     <= 1'b1;
                        bit_cnt <= '0;
                     end
                  end else if (scl_fall && got) begin
                     got <= 1'b0;
                     if (st == BS_ADDR) begin
                        if (rx_sh[BYTE_W-1:1] == dev_addr) begin
                           st      <= BS_ADDR_ACK;
                           rd_mode <= rx_sh[0];
                        end else begin
                           st <= BS_SKIP;
                        end
                     end else begin
                        st      <= BS_WR_ACK;
                        pay_vld <= 1'b1;
                     end
                  end
               end
               BS_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rd_mode) begin
                        st      <= BS_RD;
                        tx_sh   <= rd_byte;
                        bit_cnt <= '0;
                     end else begin
                        st <= BS_WR;
                     end
                  end
               end
               BS_WR_ACK: begin
                  if (scl_fall) st <= BS_WR;
               end
               BS_RD: begin
                  if (scl_fall) begin
                     if (bit_cnt == LAST_BIT) begin
                        st      <= BS_RD_ACK;
                        bit_cnt <= '0;
                     end else begin
                        tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b1};
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               BS_RD_ACK: begin
                  if (scl_rise) begin
                     m_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (m_ack) begin
                        st    <= BS_RD;
                        tx_sh <= rd_byte;
                     end else begin
                        st <= BS_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (st)
         BS_ADDR_ACK, BS_WR_ACK: sda_o = 1'b0;
         BS_RD:                  sda_o = tx_sh[BYTE_W-1];
         default:                sda_o = 1'b1;
      endcase
   end

   i2c_cmd_framer #(.BYTE_W(BYTE_W), .CO_POS(CO_POS), .DC_POS(DC_POS)) u_framer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start_p),
      .vld_i   (pay_vld),
      .byte_i  (rx_sh),
      .stb_o   (byte_stb_o),
      .dc_o    (byte_dc_o),
      .byte_o  (byte_o)
   );

   p_pull_low_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_o) |-> !scl_s);

   p_stop_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> sda_o);

   p_rd_hold_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BS_RD && $past(st) == BS_RD && scl_s && !start_p && !stop_p) |-> $stable(sda_o));

   p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BS_SKIP && $past(st) == BS_SKIP) |-> !pay_vld);

endmodule

// File: tb/test_i2c_cmd_rx.sv
module test_i2c_cmd_rx;

   localparam int Q = 8;
   localparam logic [4:0] ADDR_HI = 5'b01111;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n, scl_m, sda_m, rd_sel;
   logic [1:0] strap;
   logic [7:0] status;
   logic       sda_o, stb, dc;
   logic [7:0] byte_v;
   logic       bus;

   assign bus = sda_m & sda_o;

   i2c_cmd_rx i_i2c_cmd_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (bus),
      .strap_i     (strap),
      .rd_status_i (rd_sel),
      .status_i    (status),
      .sda_o       (sda_o),
      .byte_stb_o  (stb),
      .byte_dc_o   (dc),
      .byte_o      (byte_v)
   );

   int checks = 0;
   int errors = 0;
   logic [8:0] got_q[$];
   logic [8:0] exp_q[$];
   logic [7:0] wq[$];
   bit saw_low = 1'b0;
   bit prev_stb = 1'b0;

   always @(negedge clk) begin
      if (rst_n && stb) got_q.push_back({dc, byte_v});
      if (rst_n && !sda_o) saw_low = 1'b1;
      if (rst_n && stb && prev_stb) begin
         checks++; errors++;
         $display("FAIL R13: strobe high two cycles, actual 1 expected 0");
      end
      prev_stb = stb;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q);
         scl_m = 1'b1; tick(2 * Q);
         scl_m = 1'b0; tick(2);
      end
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      ack = ~bus; tick(Q);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic read_byte(output logic [7:0] b, input bit give_ack);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl_m = 1'b1; tick(Q);
         b[i] = bus; tick(Q);
         scl_m = 1'b0; tick(2);
      end
      sda_m = ~give_ack; tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(2);
      sda_m = 1'b1;
   endtask

   task automatic build_exp();
      int  st = 0;
      bit  co = 1'b0, f = 1'b0;
      exp_q.delete();
      foreach (wq[i]) begin
         case (st)
            0: begin co = wq[i][7]; f = wq[i][6]; st = 1; end
            1: begin exp_q.push_back({f, wq[i]}); st = 2; end
            2: begin exp_q.push_back({f, wq[i]}); st = co ? 0 : 3; end
            default: exp_q.push_back({f, wq[i]});
         endcase
      end
   endtask

   task automatic compare_out(input string req);
      chk(got_q.size() == exp_q.size(), {req, " count"}, got_q.size(), exp_q.size());
      if (got_q.size() == exp_q.size())
         foreach (exp_q[i]) chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
   endtask

   task automatic write_txn(input logic [1:0] a, input bit match);
      bit ack;
      build_exp();
      got_q.delete();
      saw_low = 1'b0;
      i2c_start();
      send_byte({ADDR_HI, a, 1'b0}, ack);
      if (match) chk(ack, "R2 address ack", ack, 1);
      else       chk(!ack, "R3 no ack on mismatch", ack, 0);
      foreach (wq[i]) begin
         send_byte(wq[i], ack);
         if (match) chk(ack, "R5 byte ack", ack, 1);
      end
      i2c_stop();
      tick(4);
      chk(sda_o == 1'b1, "R4 released after stop", sda_o, 1);
      if (match) compare_out("R7 R8 R9 payload");
      else begin
         chk(got_q.size() == 0, "R3 no strobe", got_q.size(), 0);
         chk(!saw_low, "R3 line never pulled", saw_low, 0);
      end
   endtask

   task automatic read_txn(input int n, input logic [7:0] expv);
      bit ack;
      logic [7:0] b;
      i2c_start();
      send_byte({ADDR_HI, strap, 1'b1}, ack);
      chk(ack, "R10 read address ack", ack, 1);
      for (int k = 0; k < n; k++) begin
         read_byte(b, k < n - 1);
         chk(b == expv, "R10 R11 read byte", b, expv);
      end
      tick(4);
      chk(sda_o == 1'b1, "R11 released after nack", sda_o, 1);
      tick(Q);
      chk(sda_o == 1'b1, "R11 stays released", sda_o, 1);
      i2c_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit ack;
      void'($urandom(32'd2024));
      rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
      strap = 2'b10; rd_sel = 1'b0; status = 8'h00;
      tick(5);
      chk(sda_o == 1'b1, "R1 reset sda", sda_o, 1);
      chk(stb == 1'b0, "R1 reset strobe", stb, 0);
      rst_n = 1'b1;
      tick(5);

      // R6 R8 R9: continued word then a non-continued stream
      wq = '{8'hC0, 8'hAA, 8'h55, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44};
      write_txn(2'b10, 1'b1);

      // R3: wrong strap bits in the address
      wq = '{8'h40, 8'h12, 8'h34};
      write_txn(2'b01, 1'b0);

      // R12: repeated start in the middle of a word
      got_q.delete();
      i2c_start();
      send_byte({ADDR_HI, strap, 1'b0}, ack);
      send_byte(8'h40, ack);
      send_byte(8'h12, ack);
      i2c_start();
      send_byte({ADDR_HI, strap, 1'b0}, ack);
      chk(ack, "R12 readdress ack", ack, 1);
      send_byte(8'h00, ack);
      send_byte(8'h34, ack);
      i2c_stop();
      tick(4);
      exp_q = '{9'h112, 9'h034};
      compare_out("R12 restart framing");

      // R10 R11: read address then status
      rd_sel = 1'b0;
      read_txn(3, {1'b0, ADDR_HI, strap});
      strap = 2'b01;
      read_txn(1, {1'b0, ADDR_HI, strap});
      rd_sel = 1'b1;
      status = 8'hA5;
      read_txn(2, 8'hA5);
      rd_sel = 1'b0;

      // random write transfers against the framing model
      for (int t = 0; t < 20; t++) begin
         int n = 1 + ($urandom % 10);
         logic [1:0] s = 2'($urandom);
         bit m = ($urandom % 5) != 0;
         strap = s;
         wq.delete();
         for (int i = 0; i < n; i++) wq.push_back(8'($urandom));
         write_txn(m ? s : ~s, m);
      end

      // random status reads
      for (int t = 0; t < 4; t++) begin
         rd_sel = 1'b1;
         status = 8'($urandom);
         read_txn(1 + ($urandom % 3), status);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule